// File: doc/BRIEF.md
# Absmax Vector Requantizer

This block sits between a linear compute stage that produces wide signed accumulator words and a later stage that expects compact 8-bit integers. Accumulator words arrive one per accepted cycle, tile after tile, until an end-of-vector flag arrives. Each word is stored in an internal buffer as it arrives. In the same cycle, a running maximum of magnitudes is updated, so no second pass over the data is needed to find the vector's peak.

When the vector is complete, input is held off. A sequential divider forms one reciprocal factor from the peak magnitude, and this happens once per vector. The buffer is then read back in order. Each element is converted with a single multiply, a rounding add and a shift. The result is a stream of signed 8-bit values. The peak magnitude is carried with every output element as the vector's scale. Downstream logic therefore sees a plain integer vector with one shared scale.

Top module: `absmax_requant`

## Requirements
- R1: Out of reset, `in_ready` is 1 and `out_valid` is 0.
- R2: `out_scale` equals the largest absolute value among the vector's elements, taken as a 24-bit unsigned number, so an element of -8388608 gives a scale of 8388608.
- R3: Each output equals sign(x) · floor((2·|x|·127 + m) / (2·m)), where m is the scale. This is x·127/m rounded to nearest, and the value is always within [-127, 127].
- R4: An element whose magnitude equals the scale is emitted as +127 or -127, with its own sign.
- R5: A vector whose elements are all zero gives a scale of 0, and every output is 0.
- R6: Outputs appear in the order the elements were accepted, with the same count. `out_first` is 1 only on the first element and `out_last` is 1 only on the final element.
- R7: From the acceptance of a vector's final element until its last output has been emitted, `in_ready` stays 0. Input held valid during that time is not taken and does not affect the vector in progress.
- R8: A vector that reaches MAX_LEN elements ends there even if `in_last` is 0. The next accepted word starts a new vector.
- R9: `out_scale` carries the same value on every element of one output vector, starting with the first.
- R10: A one-element vector yields +127 or -127 for a nonzero element, and 0 for a zero element.
- R11: When x·127/m lies exactly halfway between two integers, the output rounds away from zero. For example, m = 254 and x = ±1 give ±1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accumulator word present |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_data | input | ACC_W | Signed accumulator word |
| in_last | input | 1 | Marks the final word of a vector |
| out_valid | output | 1 | Quantized element present |
| out_data | output | OUT_W | Signed quantized element |
| out_first | output | 1 | First element of an output vector |
| out_last | output | 1 | Final element of an output vector |
| out_scale | output | ACC_W | Peak magnitude of the vector being emitted |

## Verification
Several properties are checked on every cycle by the assertions:
- The running peak never drops, and it covers each word as that word is accepted.
- Each reciprocal the divider produces is the exact ceiling of the quotient.
- No output element takes the code -128.
- A zero scale forces zero outputs.
- Input is never ready while output is streaming.

Other properties can only be shown by the bench's scenarios, because each depends on a whole vector:
- the exact value of each rounded element, including halfway cases;
- ±127 at the peak element;
- framing flags and element order;
- the forced end at MAX_LEN;
- the rule that a word held during emission is taken only afterwards.

// File: rtl/absq_pkg.sv
package absq_pkg;

  typedef enum logic [1:0] {
    PH_COLLECT = 2'd0,
    PH_DIVIDE  = 2'd1,
    PH_EMIT    = 2'd2
  } phase_t;

endpackage

// File: rtl/absmax_tracker.sv
module absmax_tracker #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         en,
  input  logic [W-1:0] data,
  output logic [W-1:0] mag_max
);

  logic [W-1:0] mag;

  always_comb begin
    mag = data[W-1] ? (~data + 1'b1) : data;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      mag_max <= '0;
    end else if (en && (mag > mag_max)) begin
      mag_max <= mag;
    end
  end

  // R2: the peak covers every accepted word
  assert_peak_covers_word_R2: assert property (@(posedge clk) disable iff (rst)
    (en && !clear) |=> (mag_max >= $past(mag)));

  // R2: the peak only grows until cleared
  assert_peak_monotonic_R2: assert property (@(posedge clk) disable iff (rst)
    (!clear) |=> (mag_max >= $past(mag_max)));

endmodule

// File: rtl/vec_buffer.sv
module vec_buffer #(
  parameter int W     = 24,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/recip_divider.sv
module recip_divider #(
  parameter int            DW       = 24,
  parameter int            NW       = 56,
  parameter logic [NW-1:0] DIVIDEND = '1,
  localparam int           CW       = $clog2(NW + 1),
  localparam int           PW       = NW + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quot
);

  logic [DW-1:0] d_r;
  logic [DW-1:0] rem;
  logic [NW-1:0] num_sh;
  logic [NW-1:0] q;
  logic [CW-1:0] cnt;
  logic          busy;
  logic          fin;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          ge;

  always_comb begin
    trial = {rem, num_sh[NW-1]};
    ge    = (trial >= {1'b0, d_r});
    diff  = trial - {1'b0, d_r};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_r    <= '0;
      rem    <= '0;
      num_sh <= '0;
      q      <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      fin    <= 1'b0;
      done   <= 1'b0;
      quot   <= '0;
    end else begin
      fin  <= 1'b0;
      done <= fin;
      if (start) begin
        d_r    <= divisor;
        rem    <= '0;
        q      <= '0;
        num_sh <= DIVIDEND;
        cnt    <= CW'(NW);
        busy   <= 1'b1;
      end else if (busy) begin
        rem    <= ge ? diff[DW-1:0] : trial[DW-1:0];
        q      <= {q[NW-2:0], ge};
        num_sh <= num_sh << 1;
        cnt    <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
      if (fin) begin
        quot <= q + NW'(rem != '0);
      end
    end
  end

  // R3: the factor is the exact ceiling of DIVIDEND / divisor
  assert_recip_is_ceiling_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> ((PW'(quot) * PW'(d_r) >= PW'(DIVIDEND)) &&
              ((PW'(quot) - PW'(1)) * PW'(d_r) < PW'(DIVIDEND))));

  assert_no_restart_while_busy_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);

endmodule

// File: rtl/quant_emitter.sv
module quant_emitter #(
  parameter int ACC_W   = 24,
  parameter int OUT_W   = 8,
  parameter int MAX_LEN = 256,
  parameter int NW      = 56,
  parameter int FRAC    = 49,
  localparam int AW     = $clog2(MAX_LEN),
  localparam int LW     = $clog2(MAX_LEN + 1),
  localparam int PW     = ACC_W + NW,
  localparam int QMW    = PW - FRAC,
  localparam int QMAX   = (1 << (OUT_W - 1)) - 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [LW-1:0]           len,
  input  logic [NW-1:0]           factor,
  input  logic [ACC_W-1:0]        scale,
  output logic [AW-1:0]           rd_addr,
  input  logic [ACC_W-1:0]        rd_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data,
  output logic                    out_first,
  output logic                    out_last,
  output logic [ACC_W-1:0]        out_scale,
  output logic                    done
);

  localparam logic [PW-1:0] RND = PW'(1) << (FRAC - 1);

  logic             active;
  logic [AW-1:0]    rd_idx;
  logic [LW-1:0]    len_r;
  logic [NW-1:0]    factor_r;
  logic [ACC_W-1:0] scale_r;
  logic             s1_v, s1_first, s1_last;
  logic             last_issue;

  logic             neg;
  logic [ACC_W-1:0] mag;
  logic [PW-1:0]    prod;
  logic [PW-1:0]    sum;
  logic [QMW-1:0]   qmag;
  logic [OUT_W-1:0] qsat;
  logic [OUT_W-1:0] qval;

  assign rd_addr    = rd_idx;
  assign last_issue = (LW'(rd_idx) == (len_r - 1'b1));
  assign done       = out_valid && out_last;

  always_comb begin
    neg  = rd_data[ACC_W-1];
    mag  = neg ? (~rd_data + 1'b1) : rd_data;
    prod = PW'(mag) * PW'(factor_r);
    sum  = prod + RND;
    qmag = QMW'(sum >> FRAC);
    qsat = (qmag > QMW'(QMAX)) ? OUT_W'(QMAX) : qmag[OUT_W-1:0];
    qval = neg ? (~qsat + 1'b1) : qsat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      rd_idx    <= '0;
      len_r     <= '0;
      factor_r  <= '0;
      scale_r   <= '0;
      s1_v      <= 1'b0;
      s1_first  <= 1'b0;
      s1_last   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      out_scale <= '0;
    end else begin
      if (start) begin
        active   <= 1'b1;
        rd_idx   <= '0;
        len_r    <= len;
        factor_r <= factor;
        scale_r  <= scale;
      end else if (active) begin
        rd_idx <= rd_idx + 1'b1;
        if (last_issue) begin
          active <= 1'b0;
        end
      end
      s1_v     <= active;
      s1_first <= active && (rd_idx == '0);
      s1_last  <= active && last_issue;

      out_valid <= s1_v;
      out_first <= s1_v && s1_first;
      out_last  <= s1_v && s1_last;
      if (s1_v) begin
        out_data  <= $signed(qval);
        out_scale <= scale_r;
      end
    end
  end

  // R3: the most negative code never appears
  assert_out_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data != $signed({1'b1, {(OUT_W-1){1'b0}}})));

  // R6: framing flags only on valid elements
  assert_flags_need_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (out_first || out_last) |-> out_valid);

endmodule

// File: rtl/absmax_requant.sv
module absmax_requant #(
  parameter int ACC_W   = 24,
  parameter int OUT_W   = 8,
  parameter int MAX_LEN = 256
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [ACC_W-1:0]        in_data,
  input  logic                    in_last,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data,
  output logic                    out_first,
  output logic                    out_last,
  output logic [ACC_W-1:0]        out_scale
);
  import absq_pkg::*;

  localparam int AW   = $clog2(MAX_LEN);
  localparam int LW   = $clog2(MAX_LEN + 1);
  localparam int FRAC = 2 * ACC_W + 1;
  localparam int NW   = FRAC + OUT_W - 1;
  localparam int QMAX = (1 << (OUT_W - 1)) - 1;
  localparam logic [NW-1:0] NUMER = NW'(QMAX) << FRAC;

  phase_t           phase;
  logic [AW-1:0]    wptr;
  logic [LW-1:0]    len_r;
  logic             kick;
  logic             em_start;
  logic             accept;
  logic             vec_end;
  logic [ACC_W-1:0] absmax;
  logic             div_start;
  logic             div_done;
  logic [NW-1:0]    div_quot;
  logic [NW-1:0]    factor_sel;
  logic [AW-1:0]    rd_addr;
  logic [ACC_W-1:0] rd_data;
  logic             em_done;

  assign in_ready   = (phase == PH_COLLECT);
  assign accept     = in_valid && in_ready;
  assign vec_end    = accept && (in_last || (wptr == AW'(MAX_LEN - 1)));
  assign div_start  = kick && (absmax != '0);
  assign factor_sel = (absmax == '0) ? '0 : div_quot;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_COLLECT;
      wptr     <= '0;
      len_r    <= '0;
      kick     <= 1'b0;
      em_start <= 1'b0;
    end else begin
      kick     <= 1'b0;
      em_start <= 1'b0;
      case (phase)
        PH_COLLECT: begin
          if (accept) begin
            wptr <= wptr + 1'b1;
          end
          if (vec_end) begin
            len_r <= LW'(wptr) + 1'b1;
            wptr  <= '0;
            phase <= PH_DIVIDE;
            kick  <= 1'b1;
          end
        end
        PH_DIVIDE: begin
          if ((kick && (absmax == '0)) || div_done) begin
            phase    <= PH_EMIT;
            em_start <= 1'b1;
          end
        end
        PH_EMIT: begin
          if (em_done) begin
            phase <= PH_COLLECT;
          end
        end
        default: phase <= PH_COLLECT;
      endcase
    end
  end

  absmax_tracker #(.W(ACC_W)) u_peak (
    .clk     (clk),
    .rst     (rst),
    .clear   (em_done),
    .en      (accept),
    .data    (in_data),
    .mag_max (absmax)
  );

  vec_buffer #(.W(ACC_W), .DEPTH(MAX_LEN)) u_buf (
    .clk   (clk),
    .we    (accept),
    .waddr (wptr),
    .wdata (in_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  recip_divider #(.DW(ACC_W), .NW(NW), .DIVIDEND(NUMER)) u_div (
    .clk     (clk),
    .rst     (rst),
    .start   (div_start),
    .divisor (absmax),
    .done    (div_done),
    .quot    (div_quot)
  );

  quant_emitter #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .MAX_LEN(MAX_LEN), .NW(NW), .FRAC(FRAC)
  ) u_emit (
    .clk       (clk),
    .rst       (rst),
    .start     (em_start),
    .len       (len_r),
    .factor    (factor_sel),
    .scale     (absmax),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_first (out_first),
    .out_last  (out_last),
    .out_scale (out_scale),
    .done      (em_done)
  );

  // R7: no input is taken while the previous vector is streaming out
  assert_busy_blocks_input_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R5: a zero scale yields zero elements
  assert_zero_scale_zero_out_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_scale == '0)) |-> (out_data == '0));

endmodule

// File: tb/sim_absmax_requant.sv
module sim_absmax_requant;

  localparam int ACC_W   = 24;
  localparam int OUT_W   = 8;
  localparam int MAX_LEN = 256;
  localparam longint QM  = 127;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [ACC_W-1:0] in_data = '0;
  logic in_last = 1'b0;
  logic out_valid;
  logic signed [OUT_W-1:0] out_data;
  logic out_first, out_last;
  logic [ACC_W-1:0] out_scale;

  always #5 clk = ~clk;

  absmax_requant #(.ACC_W(ACC_W), .OUT_W(OUT_W), .MAX_LEN(MAX_LEN)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_data(out_data), .out_first(out_first), .out_last(out_last),
    .out_scale(out_scale)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic signed [ACC_W-1:0] stim [MAX_LEN];
  longint cap_data  [MAX_LEN + 4];
  bit     cap_first [MAX_LEN + 4];
  bit     cap_last  [MAX_LEN + 4];
  longint cap_scale [MAX_LEN + 4];
  int     cap_n = 0;
  bit     await_out = 1'b0;
  int     busy_viol = 0;

  always @(negedge clk) begin
    if (await_out && in_ready) busy_viol++;
    if (out_valid) begin
      if (cap_n < MAX_LEN + 4) begin
        cap_data[cap_n]  = longint'(out_data);
        cap_first[cap_n] = out_first;
        cap_last[cap_n]  = out_last;
        cap_scale[cap_n] = longint'(out_scale);
      end
      cap_n++;
      if (out_last) await_out = 1'b0;
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete (actual %0d cycles, expected < 100000)", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint qexp(input longint x, input longint m);
    longint ax, q;
    if (m == 0) return 0;
    ax = (x < 0) ? -x : x;
    q = (2 * ax * QM + m) / (2 * m);
    if (q > QM) q = QM;
    return (x < 0) ? -q : q;
  endfunction

  function automatic longint peak(input int n);
    longint m = 0;
    for (int i = 0; i < n; i++) begin
      longint v = longint'(stim[i]);
      if (v < 0) v = -v;
      if (v > m) m = v;
    end
    return m;
  endfunction

  task automatic send_vec(input int n, input bit with_last);
    cap_n = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = stim[i];
      in_last  = with_last && (i == n - 1);
    end
    @(negedge clk);
    in_valid  = 1'b0;
    in_last   = 1'b0;
    await_out = 1'b1;
  endtask

  task automatic wait_out(input int n);
    int t = 0;
    while (cap_n < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(cap_n == n, "R6 element count", cap_n, n);
  endtask

  task automatic check_vec(input int n, input string vtag);
    longint m = peak(n);
    for (int i = 0; i < n; i++) begin
      longint e = qexp(longint'(stim[i]), m);
      check(cap_data[i] == e, vtag, cap_data[i], e);
      check(cap_scale[i] == m, "R9 scale on every element", cap_scale[i], m);
      check(cap_first[i] == (i == 0), "R6 first flag", longint'(cap_first[i]), longint'(i == 0));
      check(cap_last[i] == (i == n - 1), "R6 last flag", longint'(cap_last[i]), longint'(i == n - 1));
      if (m != 0) begin
        longint v = longint'(stim[i]);
        if (v == m)  check(cap_data[i] == 127,  "R4 peak to +127", cap_data[i], 127);
        if (v == -m) check(cap_data[i] == -127, "R4 peak to -127", cap_data[i], -127);
      end
    end
    check(cap_scale[0] == m, "R2 scale equals peak", cap_scale[0], m);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R1 no output after reset", longint'(out_valid), 0);
  endtask

  task automatic t_mixed;
    stim[0] = 24'sd1000;  stim[1] = -24'sd2500; stim[2] = 24'sd37;
    stim[3] = 24'sd0;     stim[4] = 24'sd2499;  stim[5] = -24'sd1;
    stim[6] = 24'sd1250;  stim[7] = -24'sd600;
    send_vec(8, 1'b1);
    wait_out(8);
    check_vec(8, "R3 mixed values");
  endtask

  task automatic t_ties;
    stim[0] = 24'sd254; stim[1] = 24'sd1;  stim[2] = -24'sd1;
    stim[3] = 24'sd3;   stim[4] = -24'sd3; stim[5] = 24'sd127;
    send_vec(6, 1'b1);
    wait_out(6);
    check_vec(6, "R11 halfway rounding");
    check(cap_data[1] == 1,  "R11 +0.5 rounds up", cap_data[1], 1);
    check(cap_data[2] == -1, "R11 -0.5 rounds away", cap_data[2], -1);
  endtask

  task automatic t_zero;
    for (int i = 0; i < 5; i++) stim[i] = '0;
    send_vec(5, 1'b1);
    wait_out(5);
    check_vec(5, "R5 zero vector");
    check(cap_scale[0] == 0, "R5 zero scale", cap_scale[0], 0);
  endtask

  task automatic t_extreme;
    stim[0] = 24'sh800000; stim[1] = 24'sh7FFFFF;
    stim[2] = 24'sd1;      stim[3] = -24'sd1;
    stim[4] = 24'sd33025;
    send_vec(5, 1'b1);
    wait_out(5);
    check_vec(5, "R3 extreme values");
    check(cap_scale[0] == 8388608, "R2 most negative input", cap_scale[0], 8388608);
  endtask

  task automatic t_single;
    stim[0] = -24'sd5;
    send_vec(1, 1'b1);
    wait_out(1);
    check_vec(1, "R10 single nonzero");
    check(cap_data[0] == -127, "R10 single to -127", cap_data[0], -127);
    stim[0] = '0;
    send_vec(1, 1'b1);
    wait_out(1);
    check(cap_data[0] == 0, "R10 single zero", cap_data[0], 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < MAX_LEN; i++) begin
      stim[i] = ACC_W'(longint'(i) * longint'(i) * 97 - longint'(i) * 5003 + 77);
    end
    send_vec(MAX_LEN, 1'b0);
    wait_out(MAX_LEN);
    check_vec(MAX_LEN, "R8 full length values");
    check(cap_last[MAX_LEN-1] == 1'b1, "R8 forced end", longint'(cap_last[MAX_LEN-1]), 1);
    stim[0] = 24'sd10; stim[1] = -24'sd20; stim[2] = 24'sd5;
    send_vec(3, 1'b1);
    wait_out(3);
    check_vec(3, "R8 next vector after forced end");
  endtask

  task automatic t_hold;
    int t = 0;
    stim[0] = 24'sd100; stim[1] = -24'sd300; stim[2] = 24'sd50;
    busy_viol = 0;
    cap_n = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = stim[i];
      in_last  = (i == 2);
    end
    @(negedge clk);
    await_out = 1'b1;
    in_data = 24'sd9000;
    in_last = 1'b1;
    while (cap_n < 3 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(cap_n == 3, "R7 held vector count", cap_n, 3);
    check_vec(3, "R7 values under held input");
    check(busy_viol == 0, "R7 ready low while busy", busy_viol, 0);
    cap_n = 0;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    stim[0] = 24'sd9000;
    wait_out(1);
    check_vec(1, "R7 held word taken afterwards");
    check(cap_scale[0] == 9000, "R7 held word scale", cap_scale[0], 9000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mixed();
    t_ties();
    t_zero();
    t_extreme();
    t_single();
    t_full();
    t_hold();
    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule